// File: doc/BRIEF.md
# Pre-Trigger Scan History Buffer

This block holds acquisition samples grouped into scans, a scan being one sample from each enabled channel, written in channel order and closed by an end-of-scan marker. While the acquisition sequencer reports the pre-trigger phase, the block keeps a sliding history of the most recent programmed number of scans. Reads are blocked in this phase. When the history is full, the first sample of each new scan pushes out the oldest whole scan, so the stored data always begins on a scan boundary.

When the sequencer moves to the post-trigger phase, the block behaves as a plain first-in first-out queue. The stored history is delivered first, oldest sample first. Reads and writes may then run in the same cycle, so an acquisition can be longer than the storage depth as long as the consumer keeps up. The sequencer pulses a synchronous clear from its idle state before each acquisition.

Both data interfaces use valid/ready. The sample input is never back-pressured: `smp_ready` is high whenever `clr` is low. A sample that cannot be stored is dropped, and the reason is reported on a flag. The output presents `rd_valid` only in the post-trigger phase when data is stored. A sample leaves on every cycle where `rd_valid` and `rd_ready` are both high. The configuration inputs must be held stable from the clear until the end of the acquisition.

Top module: `scan_history_fifo`

## Requirements
- R1: After reset or a cycle with `clr` high, `level` is 0, `rd_valid` is 0, `pre_done` is 0 and `overflow` is 0.
- R2: `cfg_error` is high when `n_chan` is 0, `n_chan` exceeds CH_MAX, `pre_scans` is 0, or `pre_scans*n_chan` exceeds DEPTH. While it is high in the pre-trigger phase, written samples are discarded and `level` does not change.
- R3: In the pre-trigger phase (`phase_post`=0), `rd_valid` stays 0, `rd_ready` is ignored, and `level` is unaffected by it.
- R4: After n complete scans in the pre-trigger phase, `level` equals min(n, `pre_scans`)*`n_chan`. Draining after the switch to post-trigger returns the most recent min(n, `pre_scans`) scans, oldest scan first, channels in written order.
- R5: With `pre_scans` scans already stored in the pre-trigger phase, the first sample of a new scan removes the oldest `n_chan` samples. `level` then becomes `pre_scans*n_chan - n_chan + 1`, and the buffer still starts on a scan boundary.
- R6: `pre_done` rises in the cycle after the end-of-scan sample that completes scan number `pre_scans` is accepted. It stays high until `clr`.
- R7: In the post-trigger phase (`phase_post`=1), `rd_valid` is high exactly when `level` is nonzero, and `rd_data` is the oldest stored sample. A write and a read in the same cycle leave `level` unchanged.
- R8: In the post-trigger phase, a sample offered while `level` equals DEPTH is discarded and `overflow` is set. `overflow` stays high until `clr`, and `level` stays at DEPTH.
- R9: `smp_ready` is the inverse of `clr`. Samples are never otherwise back-pressured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear from the sequencer idle state |
| phase_post | input | 1 | 0 = pre-trigger phase, 1 = post-trigger phase |
| n_chan | input | $clog2(CH_MAX+1) | Number of enabled channels per scan |
| pre_scans | input | QW | Pre-trigger history length in scans |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample accepted when high together with smp_valid |
| smp_data | input | DATA_W | Sample value |
| smp_last | input | 1 | Marks the last sample of a scan |
| rd_valid | output | 1 | Stored sample available |
| rd_ready | input | 1 | Consumer takes the sample |
| rd_data | output | DATA_W | Oldest stored sample |
| level | output | $clog2(DEPTH)+1 | Number of stored samples |
| pre_done | output | 1 | Pre-trigger quota reached (sticky) |
| overflow | output | 1 | Post-trigger sample lost to a full buffer (sticky) |
| cfg_error | output | 1 | History length does not fit the storage |

## Verification
A read pointer that drops the wrong number of samples shows at the first read after the phase switch: the data no longer starts at channel 0 of the expected scan. An off-by-one scan counter shows in `level` and `pre_done` one sample after the end-of-scan marker that should have triggered the drop or the flag. Count errors surface as a wrong `level` in the cycle after the offending write or read, and as `rd_valid` staying high or low too long at the end of a drain. The bench sweeps every channel count and every legal history length, with zero to two scans more than the quota, and computes the surviving scan numbers arithmetically.

// File: rtl/shfifo_pkg.sv
package shfifo_pkg;

  typedef enum logic {
    PH_PRE  = 1'b0,
    PH_POST = 1'b1
  } acq_phase_e;

endpackage

// File: rtl/shf_sample_store.sv
module shf_sample_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/shf_cfg_check.sv
module shf_cfg_check #(
  parameter int DEPTH  = 16,
  parameter int CH_MAX = 4,
  parameter int CW     = 3,
  parameter int QW     = 8,
  localparam int PW    = CW + QW
) (
  input  logic [CW-1:0] ch,
  input  logic [QW-1:0] quota,
  output logic [PW-1:0] limit,
  output logic          err
);

  assign limit = PW'(ch) * PW'(quota);

  always_comb begin
    err = 1'b0;
    if (ch == '0)                      err = 1'b1;
    if (32'(ch) > CH_MAX)              err = 1'b1;
    if (quota == '0)                   err = 1'b1;
    if (32'(limit) > DEPTH)            err = 1'b1;
  end

endmodule

// File: rtl/shf_scan_tracker.sv
module shf_scan_tracker #(
  parameter int QW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_req,
  input  logic          last,
  input  logic [QW-1:0] quota,
  output logic          drop,
  output logic          done
);

  logic          at_start;
  logic [QW-1:0] scans;

  assign drop = wr_req && at_start && (scans == quota);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_start <= 1'b1;
      scans    <= '0;
      done     <= 1'b0;
    end else if (clr) begin
      at_start <= 1'b1;
      scans    <= '0;
      done     <= 1'b0;
    end else if (wr_req) begin
      at_start <= last;
      if (last && scans != quota) scans <= scans + 1'b1;
      if (last && ({1'b0, scans} + 1'b1) == {1'b0, quota}) done <= 1'b1;
    end
  end

  // R6: once raised, the quota flag holds until a clear
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);

  // R6: the flag only rises after an accepted end-of-scan sample
  a_r6_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_req && last));

endmodule

// File: rtl/shf_occupancy.sv
module shf_occupancy #(
  parameter int DEPTH = 16,
  parameter int CW    = 3,
  parameter int PW    = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_post,
  input  logic          cfg_err,
  input  logic          s_valid,
  input  logic          m_ready,
  input  logic [CW-1:0] ch,
  input  logic [PW-1:0] limit,
  input  logic          drop,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          m_valid,
  output logic [LW-1:0] level,
  output logic          overflow
);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] count;
  logic          full, rd_fire;
  logic [LW-1:0] drop_amt;
  logic [AW-1:0] rd_step;

  assign full     = (count == LW'(DEPTH));
  assign m_valid  = in_post && (count != '0);
  assign rd_fire  = m_valid && m_ready;
  assign wr_en    = s_valid && !clr && (in_post ? !full : !cfg_err);
  assign drop_amt = drop ? LW'(ch) : '0;
  assign rd_step  = rd_fire ? AW'(1) : (drop ? AW'(ch) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + rd_step;
      count  <= count + LW'(wr_en) - LW'(rd_fire) - drop_amt;
      if (s_valid && in_post && full) overflow <= 1'b1;
    end
  end

  assign wr_addr = wr_ptr;
  assign rd_addr = rd_ptr;
  assign level   = count;

  // R3: in pre-trigger the read side moves only on a scan drop
  a_r3_rd_frozen_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_post && !clr && !drop) |=> $stable(rd_ptr));

  // R5: pre-trigger history never exceeds the programmed sample quota
  a_r5_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_post && !clr && !cfg_err) |-> (32'(count) <= 32'(limit)));

  // R2: an illegal setting stores nothing in pre-trigger
  a_r2_err_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_post && cfg_err && !clr) |=> $stable(count));

  // R8: overflow is sticky until a clear
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);

  // R8: the fill level never passes the storage depth
  a_r8_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);

endmodule

// File: rtl/scan_history_fifo.sv
module scan_history_fifo
  import shfifo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int CH_MAX = 4,
  parameter int QW     = 8,
  localparam int CW    = $clog2(CH_MAX + 1),
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1,
  localparam int PW    = CW + QW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              phase_post,
  input  logic [CW-1:0]     n_chan,
  input  logic [QW-1:0]     pre_scans,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_last,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [LW-1:0]     level,
  output logic              pre_done,
  output logic              overflow,
  output logic              cfg_error
);

  acq_phase_e    phase;
  logic [PW-1:0] limit;
  logic          pre_wr_req, drop, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;

  assign phase      = acq_phase_e'(phase_post);
  assign smp_ready  = !clr;
  assign pre_wr_req = smp_valid && !clr && (phase == PH_PRE) && !cfg_error;

  shf_cfg_check #(.DEPTH(DEPTH), .CH_MAX(CH_MAX), .CW(CW), .QW(QW)) u_cfg (
    .ch(n_chan), .quota(pre_scans), .limit(limit), .err(cfg_error)
  );

  shf_scan_tracker #(.QW(QW)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_req(pre_wr_req),
    .last(smp_last), .quota(pre_scans), .drop(drop), .done(pre_done)
  );

  shf_occupancy #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_post(phase == PH_POST),
    .cfg_err(cfg_error), .s_valid(smp_valid), .m_ready(rd_ready),
    .ch(n_chan), .limit(limit), .drop(drop), .wr_en(wr_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .m_valid(rd_valid),
    .level(level), .overflow(overflow)
  );

  shf_sample_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(smp_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R9: input never stalls outside a clear
  a_r9_ready_open: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> smp_ready);

  // R3: nothing is presented to the reader during pre-trigger
  a_r3_no_read_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRE) |-> !rd_valid);

endmodule

// File: tb/test_scan_history_fifo.sv
module test_scan_history_fifo;

  localparam int DEPTH = 16;

  logic        clk = 0, rst_n = 0, clr = 0, phase_post = 0;
  logic [2:0]  n_chan = 1;
  logic [7:0]  pre_scans = 1;
  logic        smp_valid = 0, smp_last = 0, rd_ready = 0;
  logic [15:0] smp_data = 0;
  logic        smp_ready, rd_valid, pre_done, overflow, cfg_error;
  logic [15:0] rd_data;
  logic [4:0]  level;

  int checks = 0, failures = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  scan_history_fifo i_scan_history_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .phase_post(phase_post),
    .n_chan(n_chan), .pre_scans(pre_scans), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .smp_last(smp_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .level(level), .pre_done(pre_done), .overflow(overflow),
    .cfg_error(cfg_error)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(int ch, int q);
    @(negedge clk);
    clr = 1; phase_post = 0; n_chan = 3'(ch); pre_scans = 8'(q);
    smp_valid = 0; rd_ready = 0;
    #1 chk(smp_ready == 0, "R9 ready low in clear", int'(smp_ready), 0);
    @(posedge clk); @(negedge clk);
    clr = 0;
  endtask

  task automatic put(int v, bit last);
    smp_valid = 1; smp_data = 16'(v); smp_last = last;
    @(posedge clk); @(negedge clk);
    smp_valid = 0; smp_last = 0;
  endtask

  task automatic pop(int exp, string req);
    #1;
    chk(rd_valid == 1, req, int'(rd_valid), 1);
    chk(rd_data == 16'(exp), req, int'(rd_data), exp);
    rd_ready = 1;
    @(posedge clk); @(negedge clk);
    rd_ready = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(level == 0, "R1 level after reset", int'(level), 0);
    chk(rd_valid == 0, "R1 rd_valid after reset", int'(rd_valid), 0);
    chk(pre_done == 0, "R1 pre_done after reset", int'(pre_done), 0);
    chk(overflow == 0, "R1 overflow after reset", int'(overflow), 0);
    chk(smp_ready == 1, "R9 ready after reset", int'(smp_ready), 1);

    // R4 R6 R3: sweep channel counts, quotas and scan counts
    for (int ch = 1; ch <= 4; ch++) begin
      for (int q = 1; q * ch <= DEPTH; q++) begin
        for (int n = 0; n <= q + 2; n++) begin
          int kept;
          kept = (n < q) ? n : q;
          restart(ch, q);
          chk(cfg_error == 0, "R2 legal setting", int'(cfg_error), 0);
          rd_ready = 1;
          for (int s = 0; s < n; s++)
            for (int c = 0; c < ch; c++)
              put(s * 8 + c, c == ch - 1);
          chk(rd_valid == 0, "R3 no read in pre", int'(rd_valid), 0);
          chk(int'(level) == kept * ch, "R4 level after history", int'(level), kept * ch);
          chk(pre_done == (n >= q), "R6 quota flag", int'(pre_done), int'(n >= q));
          rd_ready = 0;
          phase_post = 1;
          for (int s = n - kept; s < n; s++)
            for (int c = 0; c < ch; c++)
              pop(s * 8 + c, "R4 history order");
          #1 chk(rd_valid == 0, "R7 empty after drain", int'(rd_valid), 0);
        end
      end
    end

    // R5 R6: drop on first sample of a new scan, ch=3 q=2
    restart(3, 2);
    for (int c = 0; c < 3; c++) put(c, c == 2);
    chk(pre_done == 0, "R6 flag before quota", int'(pre_done), 0);
    for (int c = 0; c < 3; c++) put(8 + c, c == 2);
    chk(pre_done == 1, "R6 flag at quota", int'(pre_done), 1);
    for (int c = 0; c < 3; c++) put(16 + c, c == 2);
    put(24, 0);
    chk(level == 4, "R5 level after drop", int'(level), 2 * 3 - 3 + 1);
    put(25, 0);
    chk(level == 5, "R5 level partial scan", int'(level), 5);
    phase_post = 1;
    pop(16, "R5 aligned start");
    pop(17, "R5 order"); pop(18, "R5 order");
    pop(24, "R5 partial"); pop(25, "R5 partial");

    // R2: illegal settings
    restart(3, 6);
    chk(cfg_error == 1, "R2 product too big", int'(cfg_error), 1);
    for (int i = 0; i < 4; i++) put(i, i == 2);
    chk(level == 0, "R2 samples discarded", int'(level), 0);
    restart(0, 2);
    chk(cfg_error == 1, "R2 zero channels", int'(cfg_error), 1);
    restart(5, 1);
    chk(cfg_error == 1, "R2 channels above max", int'(cfg_error), 1);
    restart(2, 0);
    chk(cfg_error == 1, "R2 zero quota", int'(cfg_error), 1);
    restart(4, 4);
    chk(cfg_error == 0, "R2 exact fit", int'(cfg_error), 0);

    // R8: overflow in post-trigger
    restart(1, 1);
    phase_post = 1;
    for (int i = 0; i < DEPTH + 1; i++) put(100 + i, 1);
    chk(level == 5'(DEPTH), "R8 level capped", int'(level), DEPTH);
    chk(overflow == 1, "R8 overflow set", int'(overflow), 1);
    for (int i = 0; i < DEPTH; i++) pop(100 + i, "R8 kept samples");
    chk(overflow == 1, "R8 overflow sticky", int'(overflow), 1);
    restart(1, 1);
    chk(overflow == 0, "R1 clear drops overflow", int'(overflow), 0);
    chk(level == 0, "R1 clear empties", int'(level), 0);

    // R7: streaming with concurrent read and write
    phase_post = 1;
    put(200, 1);
    for (int i = 1; i <= 40; i++) begin
      #1;
      chk(rd_valid == 1 && rd_data == 16'(200 + i - 1), "R7 stream data",
          int'(rd_data), 200 + i - 1);
      smp_valid = 1; smp_data = 16'(200 + i); smp_last = 1; rd_ready = 1;
      @(posedge clk); @(negedge clk);
      chk(level == 1, "R7 level steady", int'(level), 1);
    end
    smp_valid = 0; rd_ready = 0;
    chk(overflow == 0, "R7 no overflow while streaming", int'(overflow), 0);
    chk(smp_ready == 1, "R9 ready when not clearing", int'(smp_ready), 1);

    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule